// File: doc/BRIEF.md
# Card Data DMA Engine

This block is a single-segment DMA engine that sits inside an SD/MMC host controller. It moves data between the card data FIFO and system memory. Software sets up a transfer through a small window of 64-bit registers. It picks a direction channel and an address mode, and writes a memory address. It then sets a go bit. The byte count arrives on a separate input. Each accepted beat carries 8 bytes. The engine raises a request to memory whenever it is busy and the card FIFO is ready. It counts the beats that memory acknowledges, and it steps the address by 8 when incrementing is enabled.

Channel 0 carries card writes, so data flows from memory to the card. Channel 1 carries card reads, so data flows from the card to memory. Each channel has a sticky completion flag and a sticky error flag, and each flag has its own mask bit. A single interrupt line combines every flag that is not masked. Each channel can be put into reset by clearing its reset bit. This aborts any transfer running on that channel and blocks new ones. Setting the bit again releases the channel.

Top module: `card_dma_engine`

## Requirements
- R1: After reset, every register reads 0 except the channel-reset register, which reads 0x300 (both channels released). irq and mem_req are both 0.
- R2: The mode register at offset 0x820 keeps only these bits: bit 16 (channel: 0 is memory-to-card, 1 is card-to-memory), bits 5:4 (bus width) and bit 0 (address increment). Every other bit reads 0, so writing all ones reads back 0x10031.
- R3: Writing 1 to bit 0 of the control register (0x828) starts a transfer when the address is 8-byte aligned and the byte count is at least 8. From the next cycle, mem_req equals fifo_rdy. The transfer lasts floor(count/8) acknowledged beats. With the increment bit set, beat k uses address base+8k.
- R4: With mode bit 0 clear, every beat of a transfer uses the base address (register 0x880).
- R5: When the last beat is acknowledged without mem_err, the channel's completion bit is set in register 0x840 (bit 16 for channel 0, bit 17 for channel 1) and mem_req falls. mem_we equals the active channel number.
- R6: A start with address bits 2:0 not all zero sets the selected channel's error bit in register 0x850 (bit 16 or 17). No request is raised.
- R7: A beat acknowledged with mem_err set sets the channel's error bit, ends the transfer and leaves the completion bit clear.
- R8: Status bits are sticky. A register write clears each bit written 0 and keeps each bit written 1. A flag that hardware sets in the same cycle as a clearing write stays set.
- R9: irq is 1 exactly when some status bit is set and its mask bit is clear. The mask registers are 0x848 and 0x858, with bits matching the status bits.
- R10: A start written while a transfer is busy is ignored. The running transfer continues unchanged.
- R11: In the reset register (0x830), bit 8 controls channel 0 and bit 9 controls channel 1. Writing a bit 0 aborts that channel's running transfer at once and sets no flag. While the bit is 0, starts on that channel are ignored. Writing it 1 releases the channel. Resetting the other channel does not affect a running transfer.
- R12: A start with a byte count below 8 and an aligned address sets the completion bit at once and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| xfer_bytes | input | CNT_W | Byte count, sampled at start |
| fifo_rdy | input | 1 | Card FIFO can take or give a beat |
| fifo_beat | output | 1 | A beat is exchanged with the card FIFO this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write to memory (channel 1) |
| mem_addr | output | ADDR_W | Memory beat address |
| mem_ack | input | 1 | Memory accepts the requested beat |
| mem_err | input | 1 | Accepted beat failed |
| irq | output | 1 | Interrupt, OR of unmasked status |

## Verification
A software write that clears status can land in the same cycle as the hardware event that sets that same flag. The bench provokes this by driving the last mem_ack of a transfer in the same cycle as a write of zeros to the completion register. It then reads the flag back and expects it to be set. A second collision is a reset-register write that arrives while the channel has a beat pending. It must drop mem_req in the next cycle and leave both status registers clear. The same write aimed at the other channel must leave the transfer running.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam logic [11:0] OFS_MODE = 12'h820;
  localparam logic [11:0] OFS_CTRL = 12'h828;
  localparam logic [11:0] OFS_RST  = 12'h830;
  localparam logic [11:0] OFS_END  = 12'h840;
  localparam logic [11:0] OFS_ENDM = 12'h848;
  localparam logic [11:0] OFS_ERR  = 12'h850;
  localparam logic [11:0] OFS_ERRM = 12'h858;
  localparam logic [11:0] OFS_ADDR = 12'h880;

  localparam int BIT_INC   = 0;
  localparam int BIT_WLO   = 4;
  localparam int BIT_WHI   = 5;
  localparam int BIT_CH    = 16;
  localparam int BIT_GO    = 0;
  localparam int BIT_RST0  = 8;
  localparam int BIT_RST1  = 9;
  localparam int BIT_FLAG0 = 16;
  localparam int BIT_FLAG1 = 17;

  localparam int NUM_CH    = 2;
  localparam int BEAT_LG   = 3;

  typedef struct packed {
    logic       ch;
    logic [1:0] width;
    logic       inc;
  } mode_t;
endpackage

// File: rtl/cdma_flag_bank.sv
module cdma_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_wdata,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         pending
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic flag_d, flag_q, mask_d, mask_q;

    always_comb begin
      flag_d = flag_q;
      if (sw_wr) flag_d = flag_q & sw_wdata[i];
      if (hw_set[i]) flag_d = 1'b1;
      mask_d = mask_wr ? mask_wdata[i] : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        mask_q <= 1'b0;
      end else begin
        flag_q <= flag_d;
        mask_q <= mask_d;
      end
    end

    assign flags[i] = flag_q;
    assign mask[i]  = mask_q;
  end

  assign pending = |(flags & ~mask);
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BEAT_W-1:0] start_beats,
  input  logic              inc,
  input  logic              abort,
  input  logic              fifo_rdy,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              beat,
  output logic              done,
  output logic              fault
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);
  localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);

  logic              busy_q, busy_d;
  logic              inc_q, inc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic              last;

  assign mem_req  = busy_q & fifo_rdy;
  assign beat     = mem_req & mem_ack;
  assign last     = (left_q == ONE);
  assign done     = beat & ~mem_err & last & ~abort;
  assign fault    = beat & mem_err & ~abort;
  assign busy     = busy_q;
  assign mem_addr = addr_q;

  always_comb begin
    busy_d = busy_q;
    inc_d  = inc_q;
    addr_d = addr_q;
    left_d = left_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      inc_d  = inc;
      addr_d = start_addr;
      left_d = start_beats;
    end else if (beat) begin
      if (mem_err || last) begin
        busy_d = 1'b0;
      end else begin
        left_d = left_q - ONE;
        if (inc_q) addr_d = addr_q + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inc_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      inc_q  <= inc_d;
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/card_dma_engine.sv
module card_dma_engine
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [CNT_W-1:0]  xfer_bytes,
  input  logic              fifo_rdy,
  output logic              fifo_beat,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);
  localparam int BEAT_W = CNT_W - BEAT_LG;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  // register write decode
  logic wr_mode, wr_ctrl, wr_rst, wr_end, wr_endm, wr_err, wr_errm, wr_addr;
  assign wr_mode = reg_wr && (reg_addr == OFS_MODE);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_rst  = reg_wr && (reg_addr == OFS_RST);
  assign wr_end  = reg_wr && (reg_addr == OFS_END);
  assign wr_endm = reg_wr && (reg_addr == OFS_ENDM);
  assign wr_err  = reg_wr && (reg_addr == OFS_ERR);
  assign wr_errm = reg_wr && (reg_addr == OFS_ERRM);
  assign wr_addr = reg_wr && (reg_addr == OFS_ADDR);

  mode_t              mode_q, mode_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [NUM_CH-1:0]  rst_q, rst_d;
  logic               ch_q, ch_d;

  logic               busy, done, fault;
  logic               ch_sel, start_acc, misalign, no_beats, launch, abort;
  logic [NUM_CH-1:0]  end_set, err_set, end_flags, err_flags, end_mask, err_mask;
  logic               end_pend, err_pend;

  assign ch_sel    = mode_q.ch;
  assign misalign  = |base_q[BEAT_LG-1:0];
  assign no_beats  = (xfer_bytes[CNT_W-1:BEAT_LG] == '0);
  assign start_acc = wr_ctrl && reg_wdata[BIT_GO] && !busy && rst_d[ch_sel];
  assign launch    = start_acc && !misalign && !no_beats;
  assign abort     = busy && !rst_d[ch_q];

  // next-state
  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.ch    = reg_wdata[BIT_CH];
      mode_d.width = reg_wdata[BIT_WHI:BIT_WLO];
      mode_d.inc   = reg_wdata[BIT_INC];
    end
    base_d = wr_addr ? reg_wdata[ADDR_W-1:0] : base_q;
    rst_d  = wr_rst ? {reg_wdata[BIT_RST1], reg_wdata[BIT_RST0]} : rst_q;
    ch_d   = launch ? ch_sel : ch_q;

    end_set = '0;
    err_set = '0;
    if (done)                               end_set[ch_q]   = 1'b1;
    if (start_acc && !misalign && no_beats) end_set[ch_sel] = 1'b1;
    if (fault)                              err_set[ch_q]   = 1'b1;
    if (start_acc && misalign)              err_set[ch_sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= '0;
      base_q <= '0;
      rst_q  <= '1;
      ch_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      base_q <= base_d;
      rst_q  <= rst_d;
      ch_q   <= ch_d;
    end
  end

  cdma_mover #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_mover (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (launch),
    .start_addr (base_q),
    .start_beats(xfer_bytes[CNT_W-1:BEAT_LG]),
    .inc        (mode_q.inc),
    .abort      (abort),
    .fifo_rdy   (fifo_rdy),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .beat       (fifo_beat),
    .done       (done),
    .fault      (fault)
  );

  cdma_flag_bank #(.N(NUM_CH)) i_end_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sw_wr     (wr_end),
    .sw_wdata  (reg_wdata[BIT_FLAG1:BIT_FLAG0]),
    .mask_wr   (wr_endm),
    .mask_wdata(reg_wdata[BIT_FLAG1:BIT_FLAG0]),
    .hw_set    (end_set),
    .flags     (end_flags),
    .mask      (end_mask),
    .pending   (end_pend)
  );

  cdma_flag_bank #(.N(NUM_CH)) i_err_bank (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sw_wr     (wr_err),
    .sw_wdata  (reg_wdata[BIT_FLAG1:BIT_FLAG0]),
    .mask_wr   (wr_errm),
    .mask_wdata(reg_wdata[BIT_FLAG1:BIT_FLAG0]),
    .hw_set    (err_set),
    .flags     (err_flags),
    .mask      (err_mask),
    .pending   (err_pend)
  );

  assign irq    = end_pend | err_pend;
  assign mem_we = ch_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_MODE: begin
        reg_rdata[BIT_CH]          = mode_q.ch;
        reg_rdata[BIT_WHI:BIT_WLO] = mode_q.width;
        reg_rdata[BIT_INC]         = mode_q.inc;
      end
      OFS_RST:  reg_rdata[BIT_RST1:BIT_RST0]   = rst_q;
      OFS_END:  reg_rdata[BIT_FLAG1:BIT_FLAG0] = end_flags;
      OFS_ENDM: reg_rdata[BIT_FLAG1:BIT_FLAG0] = end_mask;
      OFS_ERR:  reg_rdata[BIT_FLAG1:BIT_FLAG0] = err_flags;
      OFS_ERRM: reg_rdata[BIT_FLAG1:BIT_FLAG0] = err_mask;
      OFS_ADDR: reg_rdata[ADDR_W-1:0]          = base_q;
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, reg_wdata, xfer_bytes[BEAT_LG-1:0]};
endmodule

// File: rtl/cdma_checker.sv
module cdma_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        end_flags,
  input logic [1:0]        err_flags,
  input logic [1:0]        rst_q,
  input logic              ch_q,
  input logic              start_acc,
  input logic              misalign
);
  // R3: a pending, unacknowledged request keeps its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  // R6: a misaligned start raises no request
  p_misalign_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && misalign) |=> !mem_req);

  // R7: a channel never gets completion and error in the same cycle
  p_end_err_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(end_flags[0]) && $rose(err_flags[0])));

  p_end_err_apart1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(end_flags[1]) && $rose(err_flags[1])));

  // R8: without a register write, set status stays set
  p_sticky_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flags[0] && !reg_wr) |=> end_flags[0]);

  p_sticky_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[1] && !reg_wr) |=> err_flags[1]);

  // R11: a channel held in reset issues no request
  p_held_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q[ch_q] |-> !mem_req);
endmodule

bind card_dma_engine cdma_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .end_flags(end_flags),
  .err_flags(err_flags),
  .rst_q    (rst_q),
  .ch_q     (ch_q),
  .start_acc(start_acc),
  .misalign (misalign)
);

// File: tb/test_card_dma_engine.sv
`timescale 1ns/1ps
module test_card_dma_engine;
  import cdma_pkg::*;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [11:0]       reg_addr;
  logic [63:0]       reg_wdata;
  logic [63:0]       reg_rdata;
  logic [CNT_W-1:0]  xfer_bytes;
  logic              fifo_rdy, fifo_beat;
  logic              mem_req, mem_we, mem_ack, mem_err, irq;
  logic [ADDR_W-1:0] mem_addr;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  card_dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_card_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_bytes(xfer_bytes),
    .fifo_rdy(fifo_rdy), .fifo_beat(fifo_beat), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic start(input int ch, input int inc, input logic [31:0] a, input int nb);
    wr(OFS_MODE, (64'(ch) << 16) | 64'h30 | 64'(inc));
    wr(OFS_ADDR, 64'(a));
    xfer_bytes = CNT_W'(nb);
    wr(OFS_CTRL, 64'h1);
  endtask

  // full transfer with ack every cycle; checks each beat and completion
  task automatic xfer(input int ch, input int inc, input logic [31:0] a, input int nb);
    logic [63:0] v;
    start(ch, inc, a, nb);
    for (int k = 0; k < nb / 8; k++) begin
      check("R3 mem_req during transfer", 64'(mem_req), 64'h1);
      check(inc != 0 ? "R3 incrementing address" : "R4 fixed address",
            64'(mem_addr), 64'(a + (inc != 0 ? 32'(8 * k) : 32'h0)));
      check("R5 mem_we follows channel", 64'(mem_we), 64'(ch));
      mem_ack = 1'b1;
      @(negedge clk);
    end
    mem_ack = 1'b0;
    check("R5 request ends after last beat", 64'(mem_req), 64'h0);
    rd(OFS_END, v);
    check("R5 completion bit", v, 64'h1 << (16 + ch));
    rd(OFS_ERR, v);
    check("R5 no error on clean transfer", v, 64'h0);
    check("R9 irq with unmasked completion", 64'(irq), 64'h1);
    wr(OFS_END, 64'h0);
    check("R9 irq after clear", 64'(irq), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    xfer_bytes = '0; fifo_rdy = 1'b1; mem_ack = 1'b0; mem_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(OFS_MODE, v); check("R1 mode reset", v, 64'h0);
    rd(OFS_RST, v);  check("R1 reset reg reset", v, 64'h300);
    rd(OFS_END, v);  check("R1 end reset", v, 64'h0);
    rd(OFS_ERR, v);  check("R1 err reset", v, 64'h0);
    rd(OFS_ENDM, v); check("R1 end mask reset", v, 64'h0);
    rd(OFS_ERRM, v); check("R1 err mask reset", v, 64'h0);
    rd(OFS_ADDR, v); check("R1 addr reset", v, 64'h0);
    check("R1 irq reset", 64'(irq), 64'h0);
    check("R1 mem_req reset", 64'(mem_req), 64'h0);

    // R2 mode readback
    wr(OFS_MODE, '1);
    rd(OFS_MODE, v); check("R2 mode readback", v, 64'h10031);

    // R3 R4 R5 sweep over channel, address mode and length
    for (int ch = 0; ch < 2; ch++)
      for (int inc = 0; inc < 2; inc++)
        for (int nb = 1; nb <= 4; nb++)
          xfer(ch, inc, 32'h1000 + 32'((ch * 4 + inc) * 256 + nb * 64), nb * 8);

    // R3 byte count not a multiple of 8 is truncated to whole beats
    xfer(1, 1, 32'h2000, 21);

    // R6 misaligned start, every low address pattern, both channels
    for (int ch = 0; ch < 2; ch++)
      for (int lo = 1; lo < 8; lo++) begin
        start(ch, 1, 32'h3000 + 32'(lo), 16);
        check("R6 no request on misaligned", 64'(mem_req), 64'h0);
        rd(OFS_ERR, v); check("R6 error bit", v, 64'h1 << (16 + ch));
        rd(OFS_END, v); check("R6 no completion", v, 64'h0);
        wr(OFS_ERR, 64'h0);
      end

    // R7 memory error on second beat
    start(0, 1, 32'h4000, 24);
    mem_ack = 1'b1; @(negedge clk);
    mem_err = 1'b1; @(negedge clk);
    mem_ack = 1'b0; mem_err = 1'b0;
    check("R7 request drops after error", 64'(mem_req), 64'h0);
    rd(OFS_ERR, v); check("R7 error bit", v, 64'h10000);
    rd(OFS_END, v); check("R7 completion clear", v, 64'h0);

    // R9 masking
    wr(OFS_ERRM, 64'h10000);
    check("R9 masked error no irq", 64'(irq), 64'h0);
    wr(OFS_ERRM, 64'h20000);
    check("R9 other mask keeps irq", 64'(irq), 64'h1);
    wr(OFS_ERRM, 64'h0);

    // R8 write-one keeps, write-zero clears, ones never set
    wr(OFS_ERR, 64'h30000);
    rd(OFS_ERR, v); check("R8 write one keeps", v, 64'h10000);
    wr(OFS_ERR, 64'h20000);
    rd(OFS_ERR, v); check("R8 write zero clears", v, 64'h0);

    // R8 collision: last ack and clearing write in the same cycle
    start(0, 1, 32'h5000, 8);
    @(negedge clk);
    mem_ack = 1'b1; reg_wr = 1'b1; reg_addr = OFS_END; reg_wdata = 64'h0;
    @(negedge clk);
    mem_ack = 1'b0; reg_wr = 1'b0;
    rd(OFS_END, v); check("R8 hardware set beats clear", v, 64'h10000);
    wr(OFS_END, 64'h0);

    // R3 fifo not ready blocks request and beat
    start(1, 1, 32'h6000, 16);
    fifo_rdy = 1'b0; mem_ack = 1'b1; #1;
    check("R3 no request when fifo not ready", 64'(mem_req), 64'h0);
    @(negedge clk);
    fifo_rdy = 1'b1; #1;
    check("R3 address held while fifo stalled", 64'(mem_addr), 64'h6000);
    @(negedge clk); @(negedge clk);
    mem_ack = 1'b0;
    rd(OFS_END, v); check("R3 completes after stall", v, 64'h20000);
    wr(OFS_END, 64'h0);

    // R10 start while busy is ignored
    start(0, 1, 32'h7000, 16);
    wr(OFS_ADDR, 64'h7800);
    wr(OFS_CTRL, 64'h1);
    check("R10 busy start ignored", 64'(mem_addr), 64'h7000);
    mem_ack = 1'b1; @(negedge clk);
    check("R10 original transfer continues", 64'(mem_addr), 64'h7008);
    @(negedge clk);
    mem_ack = 1'b0;
    check("R10 ends after original length", 64'(mem_req), 64'h0);
    wr(OFS_END, 64'h0);

    // R11 reset of the other channel leaves transfer running
    start(1, 1, 32'h8000, 32);
    wr(OFS_RST, 64'h200);
    check("R11 other channel reset no effect", 64'(mem_req), 64'h1);
    wr(OFS_RST, 64'h300);
    // R11 reset of own channel aborts
    mem_ack = 1'b1; @(negedge clk); mem_ack = 1'b0;
    wr(OFS_RST, 64'h100);
    check("R11 abort drops request", 64'(mem_req), 64'h0);
    rd(OFS_END, v); check("R11 abort no completion", v, 64'h0);
    rd(OFS_ERR, v); check("R11 abort no error", v, 64'h0);
    wr(OFS_CTRL, 64'h1);
    check("R11 start ignored while held", 64'(mem_req), 64'h0);
    rd(OFS_RST, v); check("R11 reset reg readback", v, 64'h100);
    wr(OFS_RST, 64'h300);
    xfer(1, 1, 32'h8100, 16);

    // R12 zero length
    start(0, 1, 32'h9000, 4);
    check("R12 no request on zero beats", 64'(mem_req), 64'h0);
    rd(OFS_END, v); check("R12 immediate completion", v, 64'h10000);
    wr(OFS_END, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule